// File: doc/BRIEF.md
# Physical Memory Protection Register File

This block keeps the protection state of one hart: for every protection entry an 8-bit control byte and an address register. There can be up to 64 entries. Software reaches the state through a simple CSR port. The port takes a 12-bit CSR number, a write enable and write data, and it returns read data for the selected CSR in the same cycle. The downstream address matcher does not use the CSR port. It reads every entry's control byte and address from two wide parallel outputs.

The control bytes are packed several to a configuration CSR. With a 32-bit register width, one configuration CSR holds four entries. With a 64-bit width, one configuration CSR holds eight entries and only even CSR numbers carry state. Configuration CSRs are numbered from 0x3A0 and address CSRs from 0x3B0. Once an entry's lock bit is set, its control byte and its address are frozen until reset. A locked entry does not stop writes to the other lanes of the same configuration CSR.

Top module: `pmp_regfile`

## Requirements
- R1: After reset, every control byte and every address register reads as zero, so every entry is off and unlocked.
- R2: With XLEN=32, CSR 0x3A0+k holds entries 4k to 4k+3. Entry n sits in bits (n mod 4)*8+7 down to (n mod 4)*8. A read returns the current bytes in the same cycle.
- R3: With XLEN=64, CSR 0x3A0+2m holds entries 8m to 8m+7. Entry n sits in bits (n mod 8)*8+7 down to (n mod 8)*8.
- R4: With XLEN=64, odd configuration CSR numbers (0x3A1, 0x3A3, ...) read as zero, and writes to them change nothing.
- R5: A configuration CSR in 0x3A0 to 0x3AF that holds no implemented entry reads as zero and ignores writes. Inside an implemented CSR, a lane whose entry number is NUM_ENTRIES or above reads as zero.
- R6: Address CSR 0x3B0+n holds the full XLEN-bit address of entry n. That address appears on entry_addr bits n*XLEN+XLEN-1 down to n*XLEN.
- R7: These CSRs read as zero and ignore writes: address CSRs 0x3B0+i with i of NUM_ENTRIES or above, up to 0x3EF, and any CSR number outside 0x3A0 to 0x3EF.
- R8: In a control byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the address mode and bit 7 is the lock. These bits are stored as written. Bits 6:5 always read as zero.
- R9: While an entry's lock bit is set, writes to its control byte and to its address CSR have no effect. Only reset clears the lock. The write that sets the lock is itself stored.
- R10: A configuration CSR write updates each unlocked lane independently. Locked lanes keep their old value.
- R11: No register changes in a cycle where csr_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write enable for the selected CSR |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected CSR (combinational) |
| entry_cfg | output | NUM_ENTRIES*8 | Control bytes, entry n at bits n*8+7 down to n*8 |
| entry_addr | output | NUM_ENTRIES*XLEN | Address registers, entry n at bits n*XLEN+XLEN-1 down to n*XLEN |

## Verification
Two instances receive the same CSR traffic: one with XLEN=32 and 16 entries, one with XLEN=64 and 12 entries. A single write therefore shows how the two packings differ: a write to 0x3A1 lands in entries 4 to 7 on one instance and vanishes on the other. Byte patterns with distinct lane values catch swapped or shifted lanes. Writes with reserved bits set, and writes beyond the implemented CSR ranges, separate a stored value from an ignored one. Lock patterns change one lane at a time; they show the per-lane update, whether the lock is judged before or after the write, and that the lock clears only on reset.

// File: rtl/pmp_rf_pkg.sv
package pmp_rf_pkg;

    localparam logic [11:0] CFG_BASE   = 12'h3A0;
    localparam logic [11:0] ADDR_BASE  = 12'h3B0;
    localparam int          ADDR_SLOTS = 64;
    localparam logic [7:0]  CFG_KEEP   = 8'h9F;  // bits 6:5 reserved
    localparam int          LOCK_BIT   = 7;

    typedef struct packed {
        logic       cfg_hit;
        logic [3:0] cfg_idx;
        logic       addr_hit;
        logic [5:0] addr_idx;
    } csr_sel_t;

    // configuration CSR index that carries a given entry
    function automatic int cfg_csr_of(input int entry, input int xlen);
        return (xlen == 64) ? (entry / 8) * 2 : entry / 4;
    endfunction

    // byte lane of a given entry inside its configuration CSR
    function automatic int lane_of(input int entry, input int xlen);
        return entry % (xlen / 8);
    endfunction

endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode
    import pmp_rf_pkg::*;
(
    input  logic [11:0] csr_addr,
    output csr_sel_t    sel
);
    logic [11:0] addr_off;

    always_comb begin
        addr_off     = csr_addr - ADDR_BASE;
        sel.cfg_hit  = (csr_addr[11:4] == CFG_BASE[11:4]);
        sel.cfg_idx  = csr_addr[3:0];
        sel.addr_hit = (addr_off[11:6] == 6'd0);
        sel.addr_idx = addr_off[5:0];
    end
endmodule

// File: rtl/pmp_entry.sv
module pmp_entry #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wbyte,
    input  logic            addr_we,
    input  logic [XLEN-1:0] addr_wdata,
    output logic [7:0]      cfg_q,
    output logic [XLEN-1:0] addr_q
);
    import pmp_rf_pkg::*;

    typedef struct packed {
        logic [7:0]      cfg;
        logic [XLEN-1:0] addr;
    } ent_t;

    ent_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!state_q.cfg[LOCK_BIT]) begin
            if (cfg_we) begin
                state_d.cfg = cfg_wbyte & CFG_KEEP;
            end
            if (addr_we) begin
                state_d.addr = addr_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_q  = state_q.cfg;
    assign addr_q = state_q.addr;
endmodule

// File: rtl/pmp_read_mux.sv
module pmp_read_mux
    import pmp_rf_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16
) (
    input  csr_sel_t                     sel,
    input  logic [NUM_ENTRIES*8-1:0]    entry_cfg,
    input  logic [NUM_ENTRIES*XLEN-1:0] entry_addr,
    output logic [XLEN-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (sel.cfg_hit && sel.cfg_idx == 4'(cfg_csr_of(e, XLEN))) begin
                rdata = rdata | (XLEN'(entry_cfg[e*8 +: 8]) << (lane_of(e, XLEN) * 8));
            end
            if (sel.addr_hit && sel.addr_idx == 6'(e)) begin
                rdata = rdata | entry_addr[e*XLEN +: XLEN];
            end
        end
    end
endmodule

// File: rtl/pmp_regfile.sv
module pmp_regfile #(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csr_we,
    input  logic [11:0]                 csr_addr,
    input  logic [XLEN-1:0]             csr_wdata,
    output logic [XLEN-1:0]             csr_rdata,
    output logic [NUM_ENTRIES*8-1:0]    entry_cfg,
    output logic [NUM_ENTRIES*XLEN-1:0] entry_addr
);
    import pmp_rf_pkg::*;

    localparam int LANES = XLEN / 8;

    initial begin
        if (XLEN != 32 && XLEN != 64) $error("XLEN must be 32 or 64");
        if (NUM_ENTRIES < 1 || NUM_ENTRIES > ADDR_SLOTS) $error("NUM_ENTRIES must be 1..64");
    end

    csr_sel_t sel;

    pmp_csr_decode u_decode (
        .csr_addr (csr_addr),
        .sel      (sel)
    );

    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_entry
        localparam int CSR_I = cfg_csr_of(n, XLEN);
        localparam int LANE  = lane_of(n, XLEN);
        logic cfg_we_n, addr_we_n;

        assign cfg_we_n  = csr_we && sel.cfg_hit  && (sel.cfg_idx  == 4'(CSR_I));
        assign addr_we_n = csr_we && sel.addr_hit && (sel.addr_idx == 6'(n));

        pmp_entry #(.XLEN(XLEN)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we_n),
            .cfg_wbyte  (csr_wdata[LANE*8 +: 8]),
            .addr_we    (addr_we_n),
            .addr_wdata (csr_wdata),
            .cfg_q      (entry_cfg[n*8 +: 8]),
            .addr_q     (entry_addr[n*XLEN +: XLEN])
        );
    end

    pmp_read_mux #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES)) u_rmux (
        .sel        (sel),
        .entry_cfg  (entry_cfg),
        .entry_addr (entry_addr),
        .rdata      (csr_rdata)
    );

    if (LANES != 4 && LANES != 8) begin : g_bad_width
        initial $error("unsupported lane count");
    end
endmodule

// File: rtl/pmp_regfile_checker.sv
module pmp_regfile_checker #(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        csr_we,
    input logic [11:0]                 csr_addr,
    input logic [XLEN-1:0]             csr_rdata,
    input logic [NUM_ENTRIES*8-1:0]    entry_cfg,
    input logic [NUM_ENTRIES*XLEN-1:0] entry_addr
);
    localparam int ADDR_LO_FREE = 'h3B0 + NUM_ENTRIES;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (entry_cfg == '0 && entry_addr == '0));

    assert_addr_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(csr_addr) >= ADDR_LO_FREE && int'(csr_addr) < 'h3F0) |-> (csr_rdata == '0));

    assert_outside_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(csr_addr) < 'h3A0 || int'(csr_addr) >= 'h3F0) |-> (csr_rdata == '0));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> ($stable(entry_cfg) && $stable(entry_addr)));

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
        assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            entry_cfg[i*8+5 +: 2] == 2'b00);

        assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            entry_cfg[i*8+7] |=> ($stable(entry_cfg[i*8 +: 8]) && $stable(entry_addr[i*XLEN +: XLEN])));
    end

    if (XLEN == 64) begin : g_odd
        assert_odd_cfg_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_addr[11:4] == 8'h3A && csr_addr[0]) |-> (csr_rdata == '0));
    end
endmodule

bind pmp_regfile pmp_regfile_checker #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .csr_rdata  (csr_rdata),
    .entry_cfg  (entry_cfg),
    .entry_addr (entry_addr)
);

// File: tb/pmp_regfile_tb_top.sv
`timescale 1ns/1ps
module pmp_regfile_tb_top;
    localparam int N32 = 16;
    localparam int N64 = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] wd = '0;

    logic [31:0]        rdata32;
    logic [N32*8-1:0]   cfg32;
    logic [N32*32-1:0]  addr32;
    logic [63:0]        rdata64;
    logic [N64*8-1:0]   cfg64;
    logic [N64*64-1:0]  addr64;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  m_cfg  [2][64];
    logic [63:0] m_addr [2][64];

    always #2.5 clk = ~clk;

    pmp_regfile #(.XLEN(32), .NUM_ENTRIES(N32)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(wd[31:0]), .csr_rdata(rdata32), .entry_cfg(cfg32), .entry_addr(addr32));

    pmp_regfile #(.XLEN(64), .NUM_ENTRIES(N64)) dut64_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(wd), .csr_rdata(rdata64), .entry_cfg(cfg64), .entry_addr(addr64));

    function automatic int xl_of(input int d); return d ? 64 : 32; endfunction
    function automatic int n_of(input int d);  return d ? N64 : N32; endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++)
            for (int e = 0; e < 64; e++) begin
                m_cfg[d][e]  = 8'h00;
                m_addr[d][e] = 64'h0;
            end
    endtask

    task automatic model_write(input int d, input int a, input logic [63:0] w);
        int xl = xl_of(d);
        int n  = n_of(d);
        if (a >= 'h3A0 && a < 'h3B0) begin
            for (int e = 0; e < n; e++) begin
                int csr  = (xl == 64) ? (e / 8) * 2 : e / 4;
                int lane = e % (xl / 8);
                if (csr == a - 'h3A0 && !m_cfg[d][e][7])
                    m_cfg[d][e] = w[lane*8 +: 8] & 8'h9F;
            end
        end else if (a >= 'h3B0 && a < 'h3F0) begin
            int i = a - 'h3B0;
            if (i < n && !m_cfg[d][i][7])
                m_addr[d][i] = (xl == 32) ? {32'h0, w[31:0]} : w;
        end
    endtask

    function automatic logic [63:0] model_read(input int d, input int a);
        int xl = xl_of(d);
        int n  = n_of(d);
        logic [63:0] r = 64'h0;
        if (a >= 'h3A0 && a < 'h3B0) begin
            for (int e = 0; e < n; e++) begin
                int csr  = (xl == 64) ? (e / 8) * 2 : e / 4;
                int lane = e % (xl / 8);
                if (csr == a - 'h3A0) r[lane*8 +: 8] = m_cfg[d][e];
            end
        end else if (a >= 'h3B0 && a < 'h3F0) begin
            if (a - 'h3B0 < n) r = m_addr[d][a - 'h3B0];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        bit bad;
        chk(tag, "rdata xlen32", {32'h0, rdata32}, model_read(0, int'(csr_addr)));
        chk(tag, "rdata xlen64", rdata64, model_read(1, int'(csr_addr)));
        bad = 1'b0;
        for (int e = 0; e < N32; e++) begin
            if (cfg32[e*8 +: 8] !== m_cfg[0][e] || {32'h0, addr32[e*32 +: 32]} !== m_addr[0][e]) begin
                bad = 1'b1;
                $display("FAIL %s xlen32 entry %0d: actual cfg %h addr %h expected cfg %h addr %h",
                         tag, e, cfg32[e*8 +: 8], addr32[e*32 +: 32], m_cfg[0][e], m_addr[0][e]);
            end
        end
        checks++; if (bad) fails++;
        bad = 1'b0;
        for (int e = 0; e < N64; e++) begin
            if (cfg64[e*8 +: 8] !== m_cfg[1][e] || addr64[e*64 +: 64] !== m_addr[1][e]) begin
                bad = 1'b1;
                $display("FAIL %s xlen64 entry %0d: actual cfg %h addr %h expected cfg %h addr %h",
                         tag, e, cfg64[e*8 +: 8], addr64[e*64 +: 64], m_cfg[1][e], m_addr[1][e]);
            end
        end
        checks++; if (bad) fails++;
    endtask

    task automatic op(input string tag, input logic we, input logic [11:0] a, input logic [63:0] w);
        csr_we = we; csr_addr = a; wd = w;
        @(negedge clk);
        compare_all(tag);
        @(posedge clk);
        if (we) begin
            model_write(0, int'(a), w);
            model_write(1, int'(a), w);
        end
        #1;
    endtask

    task automatic do_reset(input string tag);
        csr_we = 1'b0; csr_addr = 12'h3A0; wd = '0;
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(posedge clk); @(negedge clk);
        compare_all(tag);
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        model_reset();
        do_reset("R1");
        op("R1", 1'b0, 12'h3B0, 64'h0);

        // distinct lanes, address-mode bits set
        op("R2", 1'b1, 12'h3A0, 64'h1F1E1D1C_1B1A0D0C);
        op("R2", 1'b0, 12'h3A0, 64'h0);
        op("R4", 1'b1, 12'h3A1, 64'h11111111_13050907);
        op("R4", 1'b0, 12'h3A1, 64'h0);
        op("R3", 1'b1, 12'h3A2, 64'h0F0E0D0C_0B0A0908);
        op("R3", 1'b0, 12'h3A2, 64'h0);
        op("R3", 1'b0, 12'h3A0, 64'h0);
        op("R5", 1'b1, 12'h3A4, 64'h07070707_07070707);
        op("R5", 1'b0, 12'h3A4, 64'h0);
        op("R5", 1'b1, 12'h3AF, 64'h05050505_05050505);
        op("R5", 1'b0, 12'h3AF, 64'h0);
        op("R4", 1'b1, 12'h3A3, 64'h01020304_18100C0B);
        op("R4", 1'b0, 12'h3A3, 64'h0);

        // reserved bits
        op("R8", 1'b1, 12'h3A0, 64'h67E76767_1F7F6160);
        op("R8", 1'b0, 12'h3A0, 64'h0);

        // address registers
        op("R6", 1'b1, 12'h3B5, 64'hDEADBEEF_12345678);
        op("R6", 1'b0, 12'h3B5, 64'h0);
        op("R6", 1'b1, 12'h3BB, 64'h00C0FFEE_87654321);
        op("R6", 1'b0, 12'h3BB, 64'h0);
        op("R7", 1'b1, 12'h3BF, 64'hAAAA5555_CAFEF00D);
        op("R7", 1'b0, 12'h3BF, 64'h0);
        op("R7", 1'b1, 12'h3EF, 64'h12345678_9ABCDEF0);
        op("R7", 1'b0, 12'h3EF, 64'h0);
        op("R7", 1'b1, 12'h3F0, 64'hFFFFFFFF_FFFFFFFF);
        op("R7", 1'b0, 12'h3F0, 64'h0);
        op("R7", 1'b1, 12'h300, 64'hFFFFFFFF_FFFFFFFF);
        op("R7", 1'b0, 12'h39F, 64'h0);

        // lock entry 1, then try to change everything
        op("R9",  1'b1, 12'h3B1, 64'h01234567_89ABCDEF);
        op("R9",  1'b1, 12'h3A0, 64'h01010101_01019D01);
        op("R9",  1'b0, 12'h3A0, 64'h0);
        op("R10", 1'b1, 12'h3A0, 64'h1F1F1F1F_1F1F1F1F);
        op("R10", 1'b0, 12'h3A0, 64'h0);
        op("R9",  1'b1, 12'h3B1, 64'hFFFFFFFF_FFFFFFFF);
        op("R9",  1'b0, 12'h3B1, 64'h0);
        op("R10", 1'b1, 12'h3A2, 64'h0A0A0A0A_0A0A8C0A);
        op("R10", 1'b1, 12'h3A2, 64'h03030303_03030303);
        op("R10", 1'b0, 12'h3A2, 64'h0);
        op("R9",  1'b1, 12'h3A0, 64'h0);
        op("R9",  1'b0, 12'h3B1, 64'h0);

        // no write enable: nothing moves
        for (int k = 0; k < 8; k++)
            op("R11", 1'b0, 12'(12'h3A0 + k * 7), 64'hFFFF0000_FFFF0000 ^ 64'(k));

        // reset lifts the lock
        do_reset("R1");
        op("R9", 1'b1, 12'h3A0, 64'h04040404_04040404);
        op("R9", 1'b1, 12'h3B1, 64'h55555555_55555555);
        op("R9", 1'b0, 12'h3B1, 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule